// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block watches the write cycles that a host places on a shared memory bus and picks out the guarded command sequences that must come before any change to the contents of a flash array. Every guarded sequence opens with the same two-write key. A third write then either completes a command, arms a one-write command, or opens a second key that leads to the erase commands. When a sequence completes, the block emits a one-cycle command pulse together with the address and data of the final write, so that a downstream engine can run the operation.

Three commands need only a single write and no key: the one that suspends an erase, the one that resumes it, and the short form of the exit from the identification modes. While the array is busy, the decoder drops every keyed sequence and only honours suspend and resume. A write that does not fit the next expected step returns the decoder to idle. That write is not treated as the first key write, so the host has to start the sequence again. Cycles in which no write is strobed leave the sequence state unchanged.

Top module: `unlock_seq_decoder`

## Requirements
- R1: The key is data AA at address 5555 followed by data 55 at address 2AAA. Only address bits 14..0 and the 8 data bits take part in any comparison, so address bit 15 has no effect. A command pulse appears on `cmd_valid` in the clock cycle after the write that completes it. That write's full address and data appear on `cmd_addr` and `cmd_data`, and `cmd_code` reads 0 whenever no pulse is present.
- R2: After the key, data A0 at 5555 arms a word program. The next write, at any address and with any data, produces code 1 with that write's address and data.
- R3: After the key, data 80 at 5555 followed by a second key opens the erase step. The sixth write produces one of three codes: code 4 for data 10 at 5555 (whole array), code 2 for data 30 at any address (sector), and code 3 for data 50 at any address (block). Data 10 at any other address, or any other data, aborts.
- R4: After the key, a third write at 5555 produces code 5 for data 90 (product-ID entry) and code 6 for data 88 (security-ID query entry). Data A5 arms a security-ID word write, and the next write produces code 7. Data 85 arms the security-ID lock, and the next write produces code 8.
- R5: Exit from the ID modes (code 9) comes from either of two forms: a single write of F0 at any address while idle, or the key followed by F0 at 5555.
- R6: While idle, a single write of B0 at any address produces code 10 (suspend), and a single write of 30 at any address produces code 11 (resume).
- R7: A write that does not fit the next expected step returns the decoder to idle and produces no pulse. That write is not taken as the start of a new key.
- R8: While `busy` is high, the decoder is held idle and produces no keyed command and no short exit. Only B0 (code 10) and 30 (code 11) still produce pulses.
- R9: A cycle with `wr_valid` low changes no sequence state and produces no pulse.
- R10: Reset clears `cmd_valid` and `cmd_code` and returns the decoder to idle, which discards any partial sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A bus write cycle is present this clock |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Low byte of the write data |
| busy | input | 1 | Array is programming or erasing |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_code | output | 4 | Command code (0 when idle) |
| cmd_addr | output | ADDR_W | Address of the completing write |
| cmd_data | output | 8 | Data of the completing write |

## Verification
The hardest behaviour to reach from the ports is the rule that an aborting write is not itself re-evaluated. A repeated AA at 5555 in the second slot would look like a fresh start to a naive design. The stimulus therefore sends exactly that write, then finishes the rest of a valid sequence, and expects silence. A second hard case is a wrong sixth write followed by 30, which must decode as a resume from idle rather than as a sector erase. The third is `busy` rising in the middle of a key, after which the third write must be ignored.

// File: rtl/usd_pkg.sv
package usd_pkg;
  localparam int CMP_W = 15;

  localparam logic [CMP_W-1:0] A_KEY_LO = 15'h5555;
  localparam logic [CMP_W-1:0] A_KEY_HI = 15'h2AAA;

  localparam logic [7:0] D_KEY_A  = 8'hAA;
  localparam logic [7:0] D_KEY_B  = 8'h55;
  localparam logic [7:0] D_WPROG  = 8'hA0;
  localparam logic [7:0] D_ERSPRE = 8'h80;
  localparam logic [7:0] D_PIDIN  = 8'h90;
  localparam logic [7:0] D_SQIN   = 8'h88;
  localparam logic [7:0] D_SQPROG = 8'hA5;
  localparam logic [7:0] D_SQLOCK = 8'h85;
  localparam logic [7:0] D_IDOUT  = 8'hF0;
  localparam logic [7:0] D_WHOLE  = 8'h10;
  localparam logic [7:0] D_SECTOR = 8'h30;
  localparam logic [7:0] D_BLOCK  = 8'h50;
  localparam logic [7:0] D_HOLD   = 8'hB0;
  localparam logic [7:0] D_GO     = 8'h30;

  typedef enum logic [3:0] {
    S_IDLE, S_K1, S_K2, S_ARM_WP, S_ARM_SQP, S_ARM_SQL, S_E3, S_E4, S_E5
  } seq_state_e;

  typedef enum logic [3:0] {
    C_NONE = 4'd0, C_WPROG = 4'd1, C_SECTOR = 4'd2, C_BLOCK = 4'd3,
    C_WHOLE = 4'd4, C_PIDIN = 4'd5, C_SQIN = 4'd6, C_SQPROG = 4'd7,
    C_SQLOCK = 4'd8, C_IDOUT = 4'd9, C_HOLD = 4'd10, C_GO = 4'd11
  } cmd_e;

  function automatic logic cyc_hit(input logic [CMP_W-1:0] a, input logic [7:0] d,
                                   input logic [CMP_W-1:0] ea, input logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction
endpackage

// File: rtl/usd_seq_fsm.sv
module usd_seq_fsm
  import usd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [CMP_W-1:0] cmp_addr,
  input  logic [7:0]       wr_data,
  input  logic             busy,
  output seq_state_e       state,
  output logic             seq_fire,
  output cmd_e             seq_code,
  output logic             seq_step,
  output logic             seq_abort
);
  seq_state_e nxt;

  always_comb begin
    nxt      = state;
    seq_fire = 1'b0;
    seq_code = C_NONE;
    seq_step = 1'b0;
    if (busy) begin
      nxt = S_IDLE;
    end else if (wr_valid) begin
      nxt = S_IDLE;
      unique case (state)
        S_IDLE: if (cyc_hit(cmp_addr, wr_data, A_KEY_LO, D_KEY_A)) begin
          nxt = S_K1; seq_step = 1'b1;
        end
        S_K1: if (cyc_hit(cmp_addr, wr_data, A_KEY_HI, D_KEY_B)) begin
          nxt = S_K2; seq_step = 1'b1;
        end
        S_K2: if (cmp_addr == A_KEY_LO) begin
          unique case (wr_data)
            D_WPROG:  begin nxt = S_ARM_WP;  seq_step = 1'b1; end
            D_ERSPRE: begin nxt = S_E3;      seq_step = 1'b1; end
            D_SQPROG: begin nxt = S_ARM_SQP; seq_step = 1'b1; end
            D_SQLOCK: begin nxt = S_ARM_SQL; seq_step = 1'b1; end
            D_PIDIN:  begin seq_fire = 1'b1; seq_code = C_PIDIN; end
            D_SQIN:   begin seq_fire = 1'b1; seq_code = C_SQIN;  end
            D_IDOUT:  begin seq_fire = 1'b1; seq_code = C_IDOUT; end
            default:  ;
          endcase
        end
        S_ARM_WP:  begin seq_fire = 1'b1; seq_code = C_WPROG;  end
        S_ARM_SQP: begin seq_fire = 1'b1; seq_code = C_SQPROG; end
        S_ARM_SQL: begin seq_fire = 1'b1; seq_code = C_SQLOCK; end
        S_E3: if (cyc_hit(cmp_addr, wr_data, A_KEY_LO, D_KEY_A)) begin
          nxt = S_E4; seq_step = 1'b1;
        end
        S_E4: if (cyc_hit(cmp_addr, wr_data, A_KEY_HI, D_KEY_B)) begin
          nxt = S_E5; seq_step = 1'b1;
        end
        S_E5: begin
          if (cyc_hit(cmp_addr, wr_data, A_KEY_LO, D_WHOLE)) begin
            seq_fire = 1'b1; seq_code = C_WHOLE;
          end else if (wr_data == D_SECTOR) begin
            seq_fire = 1'b1; seq_code = C_SECTOR;
          end else if (wr_data == D_BLOCK) begin
            seq_fire = 1'b1; seq_code = C_BLOCK;
          end
        end
        default: nxt = S_IDLE;
      endcase
    end
  end

  assign seq_abort = wr_valid && !busy && (state != S_IDLE) && !seq_step && !seq_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/usd_single_detect.sv
module usd_single_detect
  import usd_pkg::*;
(
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  input  logic       busy,
  input  logic       in_idle,
  output logic       one_fire,
  output cmd_e       one_code
);
  always_comb begin
    one_fire = 1'b0;
    one_code = C_NONE;
    if (wr_valid && (busy || in_idle)) begin
      unique case (wr_data)
        D_HOLD:  begin one_fire = 1'b1; one_code = C_HOLD; end
        D_GO:    begin one_fire = 1'b1; one_code = C_GO;   end
        D_IDOUT: if (!busy) begin one_fire = 1'b1; one_code = C_IDOUT; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/usd_cmd_reg.sv
module usd_cmd_reg
  import usd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  cmd_e              code,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output logic              cmd_valid,
  output logic [3:0]        cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_code  <= 4'd0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= fire;
      cmd_code  <= fire ? code : C_NONE;
      if (fire) begin
        cmd_addr <= addr;
        cmd_data <= data;
      end
    end
  end
endmodule

// File: rtl/unlock_seq_decoder.sv
module unlock_seq_decoder
  import usd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  output logic              cmd_valid,
  output logic [3:0]        cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data
);
  seq_state_e state;
  logic seq_fire, seq_step, seq_abort, one_fire, any_fire;
  cmd_e seq_code, one_code, any_code;

  usd_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
    .cmp_addr(wr_addr[CMP_W-1:0]), .wr_data(wr_data), .busy(busy),
    .state(state), .seq_fire(seq_fire), .seq_code(seq_code),
    .seq_step(seq_step), .seq_abort(seq_abort)
  );

  usd_single_detect u_one (
    .wr_valid(wr_valid), .wr_data(wr_data), .busy(busy),
    .in_idle(state == S_IDLE && !cyc_hit(wr_addr[CMP_W-1:0], wr_data, A_KEY_LO, D_KEY_A)),
    .one_fire(one_fire), .one_code(one_code)
  );

  assign any_fire = seq_fire | one_fire;
  assign any_code = seq_fire ? seq_code : one_code;

  usd_cmd_reg #(.ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst_n(rst_n), .fire(any_fire), .code(any_code),
    .addr(wr_addr), .data(wr_data), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );
endmodule

// File: rtl/usd_checker.sv
module usd_checker
  import usd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              busy,
  input logic              cmd_valid,
  input logic [3:0]        cmd_code,
  input logic [3:0]        st,
  input logic              abort_ev
);
  p_abort_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> (st == S_IDLE) && !cmd_valid);

  p_busy_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> st == S_IDLE);

  p_busy_filter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && $past(busy)) |-> (cmd_code == C_HOLD || cmd_code == C_GO));

  p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid && !busy) |=> $stable(st));

  p_no_write_no_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_valid) |-> !cmd_valid);

  p_prog_after_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == C_WPROG) |-> $past(st) == S_ARM_WP);

  p_whole_erase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == C_WHOLE) |->
      ($past(wr_addr[CMP_W-1:0]) == A_KEY_LO && $past(wr_data) == D_WHOLE));
endmodule

bind unlock_seq_decoder usd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wr_data(wr_data), .busy(busy), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .st(state), .abort_ev(seq_abort)
);

// File: tb/unlock_seq_decoder_bench.sv
module unlock_seq_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 56;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic busy = 1'b0;
  logic cmd_valid;
  logic [3:0] cmd_code;
  logic [15:0] cmd_addr;
  logic [7:0] cmd_data;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  unlock_seq_decoder u_unlock_seq_decoder (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  // {busy, valid, addr, data, expect_pulse, expect_code, requirement}
  localparam logic [34:0] VEC [NV] = '{
    // R2 word program
    {1'b0,1'b1,16'h5555,8'hAA,1'b0,4'd0,4'd2},
    {1'b0,1'b1,16'h2AAA,8'h55,1'b0,4'd0,4'd2},
    {1'b0,1'b1,16'h5555,8'hA0,1'b0,4'd0,4'd2},
    {1'b0,1'b1,16'h1234,8'h5A,1'b1,4'd1,4'd2},
    // R1 address bit 15 ignored, full address returned
    {1'b0,1'b1,16'hD555,8'hAA,1'b0,4'd0,4'd1},
    {1'b0,1'b1,16'hAAAA,8'h55,1'b0,4'd0,4'd1},
    {1'b0,1'b1,16'hD555,8'hA0,1'b0,4'd0,4'd1},
    {1'b0,1'b1,16'h8001,8'h3C,1'b1,4'd1,4'd1},
    // R3 sector erase
    {1'b0,1'b1,16'h5555,8'hAA,1'b0,4'd0,4'd3},
    {1'b0,1'b1,16'h2AAA,8'h55,1'b0,4'd0,4'd3},
    {1'b0,1'b1,16'h5555,8'h80,1'b0,4'd0,4'd3},
    {1'b0,1'b1,16'h5555,8'hAA,1'b0,4'd0,4'd3},
    {1'b0,1'b1,16'h2AAA,8'h55,1'b0,4'd0,4'd3},
    {1'b0,1'b1,16'h0840,8'h30,1'b1,4'd2,4'd3},
    // R3 block erase
    {1'b0,1'b1,16'h5555,8'hAA,1'b0,4'd0,4'd3},
    {1'b0,1'b1,16'h2AAA,8'h55,1'b0,4'd0,4'd3},
    {1'b0,1'b1,16'h5555,8'h80,1'b0,4'd0,4'd3},
    {1'b0,1'b1,16'h5555,8'hAA,1'b0,4'd0,4'd3},
    {1'b0,1'b1,16'h2AAA,8'h55,1'b0,4'd0,4'd3},
    {1'b0,1'b1,16'h8000,8'h50,1'b1,4'd3,4'd3},
    // R3 whole-array erase
    {1'b0,1'b1,16'h5555,8'hAA,1'b0,4'd0,4'd3},
    {1'b0,1'b1,16'h2AAA,8'h55,1'b0,4'd0,4'd3},
    {1'b0,1'b1,16'h5555,8'h80,1'b0,4'd0,4'd3},
    {1'b0,1'b1,16'h5555,8'hAA,1'b0,4'd0,4'd3},
    {1'b0,1'b1,16'h2AAA,8'h55,1'b0,4'd0,4'd3},
    {1'b0,1'b1,16'h5555,8'h10,1'b1,4'd4,4'd3},
    // R4 product-ID entry, security query, security write, security lock
    {1'b0,1'b1,16'h5555,8'hAA,1'b0,4'd0,4'd4},
    {1'b0,1'b1,16'h2AAA,8'h55,1'b0,4'd0,4'd4},
    {1'b0,1'b1,16'h5555,8'h90,1'b1,4'd5,4'd4},
    {1'b0,1'b1,16'h5555,8'hAA,1'b0,4'd0,4'd4},
    {1'b0,1'b1,16'h2AAA,8'h55,1'b0,4'd0,4'd4},
    {1'b0,1'b1,16'h5555,8'h88,1'b1,4'd6,4'd4},
    {1'b0,1'b1,16'h5555,8'hAA,1'b0,4'd0,4'd4},
    {1'b0,1'b1,16'h2AAA,8'h55,1'b0,4'd0,4'd4},
    {1'b0,1'b1,16'h5555,8'hA5,1'b0,4'd0,4'd4},
    {1'b0,1'b1,16'h0010,8'hEF,1'b1,4'd7,4'd4},
    {1'b0,1'b1,16'h5555,8'hAA,1'b0,4'd0,4'd4},
    {1'b0,1'b1,16'h2AAA,8'h55,1'b0,4'd0,4'd4},
    {1'b0,1'b1,16'h5555,8'h85,1'b0,4'd0,4'd4},
    {1'b0,1'b1,16'h0000,8'h00,1'b1,4'd8,4'd4},
    // R5 exit, keyed and short
    {1'b0,1'b1,16'h5555,8'hAA,1'b0,4'd0,4'd5},
    {1'b0,1'b1,16'h2AAA,8'h55,1'b0,4'd0,4'd5},
    {1'b0,1'b1,16'h5555,8'hF0,1'b1,4'd9,4'd5},
    {1'b0,1'b1,16'h7777,8'hF0,1'b1,4'd9,4'd5},
    // R6 suspend and resume
    {1'b0,1'b1,16'h0123,8'hB0,1'b1,4'd10,4'd6},
    {1'b0,1'b1,16'h4444,8'h30,1'b1,4'd11,4'd6},
    // R7 wrong second write aborts; later writes do not resume the sequence
    {1'b0,1'b1,16'h5555,8'hAA,1'b0,4'd0,4'd7},
    {1'b0,1'b1,16'h2AAB,8'h55,1'b0,4'd0,4'd7},
    {1'b0,1'b1,16'h2AAA,8'h55,1'b0,4'd0,4'd7},
    {1'b0,1'b1,16'h5555,8'hA0,1'b0,4'd0,4'd7},
    {1'b0,1'b1,16'h1234,8'h11,1'b0,4'd0,4'd7},
    // R7 a repeated AA is an abort, not a restart
    {1'b0,1'b1,16'h5555,8'hAA,1'b0,4'd0,4'd7},
    {1'b0,1'b1,16'h5555,8'hAA,1'b0,4'd0,4'd7},
    {1'b0,1'b1,16'h2AAA,8'h55,1'b0,4'd0,4'd7},
    {1'b0,1'b1,16'h5555,8'hA0,1'b0,4'd0,4'd7},
    {1'b0,1'b1,16'h0001,8'h22,1'b0,4'd0,4'd7}
  };

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic b, input logic v, input logic [15:0] a,
                      input logic [7:0] d, input logic ev, input logic [3:0] ec,
                      input int req);
    busy = b; wr_valid = v; wr_addr = a; wr_data = d;
    @(negedge clk);
    chk(cmd_valid == ev && cmd_code == (ev ? ec : 4'd0), req, "pulse/code",
        {27'd0, cmd_valid, cmd_code}, {27'd0, ev, (ev ? ec : 4'd0)});
    if (ev) chk(cmd_addr == a && cmd_data == d, req, "addr/data",
                {8'd0, cmd_addr, cmd_data}, {8'd0, a, d});
    wr_valid = 1'b0; busy = 1'b0;
  endtask

  task automatic erase_prefix(input int req);
    step(0,1,16'h5555,8'hAA,0,0,req);
    step(0,1,16'h2AAA,8'h55,0,0,req);
    step(0,1,16'h5555,8'h80,0,0,req);
    step(0,1,16'h5555,8'hAA,0,0,req);
    step(0,1,16'h2AAA,8'h55,0,0,req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(cmd_valid == 1'b0 && cmd_code == 4'd0, 10, "reset outputs",
        {27'd0, cmd_valid, cmd_code}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][34], VEC[i][33], VEC[i][32:17], VEC[i][16:9],
           VEC[i][8], VEC[i][7:4], int'(VEC[i][3:0]));
    end

    // R9 cycles without a write between sequence steps
    step(0,1,16'h5555,8'hAA,0,0,9);
    step(0,0,16'h0000,8'h00,0,0,9);
    step(0,1,16'h2AAA,8'h55,0,0,9);
    step(0,0,16'h5555,8'hF0,0,0,9);
    step(0,1,16'h5555,8'hA0,0,0,9);
    step(0,0,16'h0000,8'hB0,0,0,9);
    step(0,1,16'h0002,8'h33,1,1,9);

    // R8 busy drops keyed sequences and the short exit, keeps suspend/resume
    step(1,1,16'h5555,8'hAA,0,0,8);
    step(1,1,16'h2AAA,8'h55,0,0,8);
    step(1,1,16'h5555,8'h90,0,0,8);
    step(1,1,16'h5555,8'hF0,0,0,8);
    step(1,1,16'h0ABC,8'hB0,1,10,8);
    step(1,1,16'h0DEF,8'h30,1,11,8);

    // R8 busy rising mid-key discards the partial sequence
    step(0,1,16'h5555,8'hAA,0,0,8);
    step(0,1,16'h2AAA,8'h55,0,0,8);
    step(1,0,16'h0000,8'h00,0,0,8);
    step(0,1,16'h5555,8'hA0,0,0,8);
    step(0,1,16'h0003,8'h44,0,0,8);

    // R3/R7 wrong sixth write aborts; the next 30 is a resume from idle
    erase_prefix(3);
    step(0,1,16'h5555,8'h20,0,0,7);
    step(0,1,16'h1234,8'h30,1,11,7);

    // R3 whole-array data at a non-key address aborts
    erase_prefix(3);
    step(0,1,16'h1000,8'h10,0,0,3);
    step(0,1,16'h0000,8'h33,0,0,3);

    // R7 right data at the wrong third address aborts
    step(0,1,16'h5555,8'hAA,0,0,7);
    step(0,1,16'h2AAA,8'h55,0,0,7);
    step(0,1,16'h5554,8'hA0,0,0,7);
    step(0,1,16'h0000,8'h33,0,0,7);

    // R10 reset discards a partial sequence
    step(0,1,16'h5555,8'hAA,0,0,10);
    step(0,1,16'h2AAA,8'h55,0,0,10);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step(0,1,16'h5555,8'hA0,0,0,10);
    step(0,1,16'h0004,8'h55,0,0,10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule